// File: doc/BRIEF.md
# Register-Sourced Condition Evaluator

This block reduces a compact condition field to one decision bit for a branch or skip unit. The field names a register and a test. The pipeline's operand read multiplexer has already fetched the named register. Its value arrives next to the field, so no dedicated flag register is involved. For an ordinary register, the block tests the value for all-zero, for its top (sign) bit, or for its bottom bit. A fourth test ignores the register value and uses the register number to pick one of sixteen external condition bits. Those bits can be wired to register bits, peripheral status or pins.

Register index 0 stands for the program counter. Its value is never a useful condition, so that index is given other meanings. The zero test returns constant true, and the sign test returns the carry flag, which the ALU holds and this block only reads. A top field bit can invert any result. The result is registered, and a valid flag follows the input strobe by one clock.

Top module: `cond_eval`

## Requirements
- R1: The 7-bit condition field is laid out as register number in bits [3:0], test code in bits [5:4] and invert in bit 6.
- R2: For a register other than 0, test code 00 yields 1 exactly when the supplied 16-bit value is all zeros.
- R3: For a register other than 0, test code 01 yields bit 15 (the sign) of the supplied value.
- R4: For a register other than 0, test code 10 yields bit 0 of the supplied value.
- R5: For a register other than 0, test code 11 yields the external condition bit whose index equals the register number, and the supplied value has no effect.
- R6: For register 0, test code 00 yields 1 whatever the supplied value is.
- R7: For register 0, test code 01 yields the carry input. The carry input has no effect for any other register or test.
- R8: For register 0, test codes 10 and 11 yield 0.
- R9: When the invert bit is 1, the result of the selected test is complemented.
- R10: The condition output and the output valid flag update one clock after the inputs are sampled with the input strobe high. The output valid flag equals the input strobe of the previous cycle.
- R11: While the input strobe is low, the condition output keeps its last value, whatever the other inputs do.
- R12: Synchronous active-high reset clears the output valid flag and the condition output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking a condition to evaluate |
| cond_field | input | 7 | Condition field: invert, test code, register number |
| rd_value | input | 16 | Value of the named register from the operand read mux |
| carry_in | input | 1 | Carry flag held by the ALU |
| ext_bits | input | 16 | External condition bits for the bit-select test |
| out_valid | output | 1 | Registered copy of in_valid |
| out_cond | output | 1 | Registered condition bit |

## Verification
Register 0 gets the most attention, because a design that skipped the special case would test the program counter value itself. Such a design would return a zero test on a non-zero value as false instead of true, would return the sign bit instead of the carry, and could leak the bottom bit or external bit 0 through tests 10 and 11. The bit-select test is driven at index 9 and at the top index 15, with the supplied value set to disagree. A wrong mux index or a mix-up with the register value then shows up as a flipped result. Invert is applied across the special cases, and the hold behaviour is probed with an idle strobe and inputs that would flip the output. Both catch designs that drop the invert or that load the output register on every clock.

// File: rtl/cond_eval_pkg.sv
`timescale 1ns/1ps
package cond_eval_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    TST_ZERO   = 2'b00,
    TST_SIGN   = 2'b01,
    TST_LSB    = 2'b10,
    TST_BITSEL = 2'b11
  } test_e;

  typedef struct packed {
    logic             invert;
    test_e            test;
    logic [IDX_W-1:0] reg_sel;
  } cond_field_t;
endpackage

// File: rtl/cond_field_decode.sv
`timescale 1ns/1ps
module cond_field_decode
  import cond_eval_pkg::*;
#(
  parameter int PC_INDEX = 0
) (
  input  logic [IDX_W+2:0]  field_in,
  output logic [IDX_W-1:0]  reg_sel,
  output test_e             test,
  output logic              invert,
  output logic              is_pc
);
  cond_field_t f;

  always_comb begin
    f       = cond_field_t'(field_in);
    reg_sel = f.reg_sel;
    test    = f.test;
    invert  = f.invert;
    is_pc   = (f.reg_sel == IDX_W'(PC_INDEX));
  end
endmodule

// File: rtl/cond_reg_test.sv
`timescale 1ns/1ps
module cond_reg_test
  import cond_eval_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] value,
  input  test_e             test,
  output logic              bit_out
);
  logic is_zero;

  assign is_zero = ~|value;

  always_comb begin
    unique case (test)
      TST_ZERO: bit_out = is_zero;
      TST_SIGN: bit_out = value[DATA_W-1];
      TST_LSB:  bit_out = value[0];
      default:  bit_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/cond_ext_select.sv
`timescale 1ns/1ps
module cond_ext_select #(
  parameter int SEL_W = 4,
  localparam int NBITS = 1 << SEL_W
) (
  input  logic [NBITS-1:0] ext_bits,
  input  logic [SEL_W-1:0] sel,
  output logic             bit_out
);
  logic [NBITS-1:0] onehot;

  for (genvar i = 0; i < NBITS; i++) begin : g_dec
    assign onehot[i] = (sel == SEL_W'(i));
  end

  assign bit_out = |(onehot & ext_bits);
endmodule

// File: rtl/cond_eval.sv
`timescale 1ns/1ps
module cond_eval
  import cond_eval_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PC_INDEX = 0,
  localparam int FIELD_W = IDX_W + 3,
  localparam int EXT_W   = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [FIELD_W-1:0] cond_field,
  input  logic [DATA_W-1:0]  rd_value,
  input  logic               carry_in,
  input  logic [EXT_W-1:0]   ext_bits,
  output logic               out_valid,
  output logic               out_cond
);
  logic [IDX_W-1:0] reg_sel;
  test_e            test;
  logic             invert;
  logic             is_pc;
  logic             reg_bit;
  logic             ext_bit;
  logic             raw_bit;
  logic             pc_bit;

  cond_field_decode #(.PC_INDEX(PC_INDEX)) u_decode (
    .field_in (cond_field),
    .reg_sel  (reg_sel),
    .test     (test),
    .invert   (invert),
    .is_pc    (is_pc)
  );

  cond_reg_test #(.DATA_W(DATA_W)) u_reg_test (
    .value   (rd_value),
    .test    (test),
    .bit_out (reg_bit)
  );

  cond_ext_select #(.SEL_W(IDX_W)) u_ext_sel (
    .ext_bits (ext_bits),
    .sel      (reg_sel),
    .bit_out  (ext_bit)
  );

  always_comb begin
    unique case (test)
      TST_ZERO: pc_bit = 1'b1;
      TST_SIGN: pc_bit = carry_in;
      default:  pc_bit = 1'b0;
    endcase
    if (is_pc)                 raw_bit = pc_bit;
    else if (test == TST_BITSEL) raw_bit = ext_bit;
    else                       raw_bit = reg_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_cond  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_cond <= raw_bit ^ invert;
    end
  end
endmodule

// File: rtl/cond_eval_chk.sv
`timescale 1ns/1ps
module cond_eval_chk #(
  parameter int DATA_W   = 16,
  parameter int PC_INDEX = 0
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [6:0]  cond_field,
  input logic [DATA_W-1:0] rd_value,
  input logic        carry_in,
  input logic [15:0] ext_bits,
  input logic        out_valid,
  input logic        out_cond
);
  logic sel_pc;
  assign sel_pc = (cond_field[3:0] == 4'(PC_INDEX));

  assert_valid_rise_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_cond));
  assert_pc_always_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_pc && cond_field[5:4] == 2'b00)
      |=> (out_cond == !$past(cond_field[6])));
  assert_pc_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_pc && cond_field[5:4] == 2'b01)
      |=> (out_cond == ($past(carry_in) ^ $past(cond_field[6]))));
  assert_pc_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_pc && cond_field[5])
      |=> (out_cond == $past(cond_field[6])));
  assert_zero_test_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sel_pc && cond_field[5:4] == 2'b00)
      |=> (out_cond == (($past(rd_value) == '0) ^ $past(cond_field[6]))));
  assert_bitsel_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sel_pc && cond_field[5:4] == 2'b11)
      |=> (out_cond == ($past(ext_bits[cond_field[3:0]]) ^ $past(cond_field[6]))));
endmodule

bind cond_eval cond_eval_chk #(.DATA_W(DATA_W), .PC_INDEX(PC_INDEX)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .cond_field(cond_field),
  .rd_value(rd_value), .carry_in(carry_in), .ext_bits(ext_bits),
  .out_valid(out_valid), .out_cond(out_cond)
);

// File: tb/cond_eval_tb.sv
`timescale 1ns/1ps
module cond_eval_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [6:0]  cond_field = '0;
  logic [15:0] rd_value = '0;
  logic        carry_in = 1'b0;
  logic [15:0] ext_bits = '0;
  logic        out_valid;
  logic        out_cond;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cond_eval u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cond_field(cond_field),
    .rd_value(rd_value), .carry_in(carry_in), .ext_bits(ext_bits),
    .out_valid(out_valid), .out_cond(out_cond)
  );

  // {field(7), value(16), carry(1), ext(16), expected(1)}
  localparam int NV = 19;
  localparam logic [40:0] VEC [NV] = '{
    {7'b0_00_0101, 16'h0000, 1'b0, 16'h0000, 1'b1}, // R2 zero
    {7'b0_00_0101, 16'h0010, 1'b0, 16'h0000, 1'b0}, // R2 nonzero
    {7'b0_01_0011, 16'h8000, 1'b0, 16'h0000, 1'b1}, // R3
    {7'b0_01_0011, 16'h7FFF, 1'b1, 16'h0000, 1'b0}, // R3, carry ignored (R7)
    {7'b0_10_0111, 16'h0001, 1'b0, 16'h0000, 1'b1}, // R4
    {7'b0_10_0111, 16'hFFFE, 1'b0, 16'hFFFF, 1'b0}, // R4
    {7'b0_11_1001, 16'h0000, 1'b0, 16'h0200, 1'b1}, // R5 index 9
    {7'b0_11_1001, 16'hFFFF, 1'b0, 16'hFDFF, 1'b0}, // R5 value ignored
    {7'b0_00_0000, 16'h1234, 1'b0, 16'h0000, 1'b1}, // R6
    {7'b0_01_0000, 16'h0000, 1'b1, 16'h0000, 1'b1}, // R7
    {7'b0_01_0000, 16'hFFFF, 1'b0, 16'hFFFF, 1'b0}, // R7
    {7'b0_10_0000, 16'h0001, 1'b1, 16'hFFFF, 1'b0}, // R8
    {7'b0_11_0000, 16'hFFFF, 1'b1, 16'hFFFF, 1'b0}, // R8
    {7'b1_00_0101, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R9 on R2
    {7'b1_00_0000, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R9 on R6
    {7'b1_11_0000, 16'h0000, 1'b0, 16'h0000, 1'b1}, // R9 on R8
    {7'b1_01_0011, 16'h8000, 1'b0, 16'h0000, 1'b0}, // R9 on R3
    {7'b0_11_1111, 16'h0000, 1'b0, 16'h8000, 1'b1}, // R5 top index
    {7'b0_00_0010, 16'h0000, 1'b1, 16'h0000, 1'b1}  // R2 with carry set
  };

  function automatic string req_of(logic [6:0] f);
    if (f[6]) return "R9";
    if (f[3:0] == 4'd0) begin
      case (f[5:4])
        2'b00:   return "R6";
        2'b01:   return "R7";
        default: return "R8";
      endcase
    end
    case (f[5:4])
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [6:0] f, logic [15:0] val, logic c, logic [15:0] e);
    @(negedge clk);
    in_valid = v; cond_field = f; rd_value = val; carry_in = c; ext_bits = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R12", out_valid, 1'b0);
    check("R12", out_cond, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // table walked back to back: every result one clock after sampling (R10)
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][40:34], VEC[i][33:18], VEC[i][17], VEC[i][16:1]);
      check("R10", out_valid, 1'b1);
      check(req_of(VEC[i][40:34]), out_cond, VEC[i][0]);
    end

    // R1: field position check, invert=1 test=LSB reg=6, value LSB=1 -> 0
    drive(1'b1, 7'b1_10_0110, 16'h0001, 1'b0, 16'h0000);
    check("R1", out_cond, 1'b0);
    // R1: same bits with test/reg swapped meaning would differ; reg 6 bitsel
    drive(1'b1, 7'b0_11_0110, 16'h0000, 1'b0, 16'h0040);
    check("R1", out_cond, 1'b1);

    // R11: idle strobe with inputs that would give 0 if loaded
    drive(1'b0, 7'b1_00_0000, 16'h0000, 1'b0, 16'h0000);
    check("R10", out_valid, 1'b0);
    check("R11", out_cond, 1'b1);
    drive(1'b0, 7'b0_11_0110, 16'h0000, 1'b0, 16'h0000);
    check("R11", out_cond, 1'b1);

    // R10: output changes only after the sampling edge
    drive(1'b1, 7'b0_00_0000, 16'h0000, 1'b0, 16'h0000);
    check("R6", out_cond, 1'b1);
    @(negedge clk);
    in_valid = 1'b1; cond_field = 7'b0_10_0000;
    #1;
    check("R10", out_cond, 1'b1);
    @(posedge clk); #1;
    check("R8", out_cond, 1'b0);

    // R12: mid-run reset
    drive(1'b1, 7'b0_00_0000, 16'h0000, 1'b0, 16'h0000);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R12", out_valid, 1'b0);
    check("R12", out_cond, 1'b0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule